// File: doc/BRIEF.md
# Single-Precision Floating-Point Comparator with Operand Class Bits

This block orders two IEEE-754 single-precision operands and returns a 32-bit result word. Four bits of that word form a one-hot relation code (less, equal, greater, unordered). Two further bits mark each operand that is subnormal. The comparison is quiet: a quiet NaN operand only produces the unordered code, and only a signaling NaN operand raises the invalid exception. A downstream flag register is expected to collect that exception.

Subnormal operands are never flushed to zero, so they are ordered by their true value. Positive and negative zero are treated as the same value. The decision logic is combinational. One output register stage, loaded under a clock enable, holds the result word and the exception bit. Reset is asynchronous, active low, and its release is synchronised inside the block.

Top module: `fp_cmp_unit`

## Requirements
- R1: The result word has bit 0 = A less than B, bit 1 = A equal to B, bit 2 = A greater than B and bit 3 = unordered, and exactly one of bits 3:0 is set after any loaded comparison.
- R2: Bit 4 is set when A is subnormal and bit 5 is set when B is subnormal (exponent field all zeros, fraction nonzero). This holds whatever the relation code is.
- R3: Subnormal operands are ordered by their true value. For example, the smallest positive subnormal is greater than +0 and less than the smallest positive normal number.
- R4: +0 and -0 compare equal in either order.
- R5: When either operand is a NaN (exponent all ones, fraction nonzero), the relation code is unordered, regardless of the other operand.
- R6: The invalid output is 1 exactly when at least one operand is a signaling NaN, meaning fraction bit 22 is 0 with a nonzero fraction. A quiet NaN (fraction bit 22 = 1) gives unordered without invalid.
- R7: When no operand is a signaling NaN, the invalid output is 0.
- R8: Bits 31:6 of the result word are always 0.
- R9: The outputs reflect the operands presented with `cmp_en` high, one clock later. While `cmp_en` is low, the outputs hold their values.
- R10: During reset and until the first loaded comparison, the result word and the invalid output are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_en | input | 1 | Load enable for the output register stage |
| opa | input | 32 | Operand A, single-precision bit pattern |
| opb | input | 32 | Operand B, single-precision bit pattern |
| cmp_res | output | 32 | Registered relation code and subnormal markers |
| cmp_inv | output | 1 | Registered invalid exception |

## Verification
Uniform random bit patterns almost never land on zeros, subnormals, infinities or NaNs of a chosen flavour. A single random draw is therefore very unlikely to show a signaling NaN against a subnormal, or a subnormal against a zero of the opposite sign. The stimulus builds each operand from a class pick (signed zero, subnormal, normal, infinity, quiet NaN or signaling NaN) with random fill in the free fields. It pairs operands that share magnitude bits and differ only in sign, or in the lowest fraction bit, so that the boundary between equal and unequal is hit often. Directed vectors add the smallest subnormal against zero and the largest subnormal against the smallest normal.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  localparam int unsigned REL_LT  = 0;
  localparam int unsigned REL_EQ  = 1;
  localparam int unsigned REL_GT  = 2;
  localparam int unsigned REL_UN  = 3;
  localparam int unsigned REL_W   = 4;
  localparam int unsigned DEN_A   = 4;
  localparam int unsigned DEN_B   = 5;

  typedef struct packed {
    logic sign;
    logic is_zero;
    logic is_sub;
    logic is_inf;
    logic is_nan;
    logic is_snan;
  } fcls_t;

endpackage

// File: rtl/fcmp_rst_sync.sv
module fcmp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] op,
  output fcls_t                cls
);

  localparam int unsigned W = 1 + EXP_W + MAN_W;

  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] fr;
  logic             ex_zero;
  logic             ex_ones;
  logic             fr_zero;

  always_comb begin
    ex      = op[W-2:MAN_W];
    fr      = op[MAN_W-1:0];
    ex_zero = (ex == '0);
    ex_ones = (ex == '1);
    fr_zero = (fr == '0);

    cls.sign    = op[W-1];
    cls.is_zero = ex_zero && fr_zero;
    cls.is_sub  = ex_zero && !fr_zero;
    cls.is_inf  = ex_ones && fr_zero;
    cls.is_nan  = ex_ones && !fr_zero;
    cls.is_snan = ex_ones && !fr_zero && !fr[MAN_W-1];
  end

endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
  import fcmp_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] opa,
  input  logic [EXP_W+MAN_W:0] opb,
  input  fcls_t                cls_a,
  input  fcls_t                cls_b,
  output logic [REL_W-1:0]     rel
);

  localparam int unsigned MAG_W = EXP_W + MAN_W;

  logic [MAG_W-1:0] mag_a;
  logic [MAG_W-1:0] mag_b;
  logic             mag_gt;
  logic             a_above;

  always_comb begin
    mag_a   = opa[MAG_W-1:0];
    mag_b   = opb[MAG_W-1:0];
    mag_gt  = (mag_a > mag_b);
    a_above = 1'b0;
    rel     = '0;

    if (cls_a.is_nan || cls_b.is_nan) begin
      rel[REL_UN] = 1'b1;
    end else if (cls_a.is_zero && cls_b.is_zero) begin
      rel[REL_EQ] = 1'b1;
    end else if (opa == opb) begin
      rel[REL_EQ] = 1'b1;
    end else begin
      if (cls_a.sign != cls_b.sign) begin
        a_above = !cls_a.sign;
      end else if (cls_a.sign) begin
        a_above = !mag_gt;
      end else begin
        a_above = mag_gt;
      end
      if (a_above) begin
        rel[REL_GT] = 1'b1;
      end else begin
        rel[REL_LT] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/fp_cmp_unit.sv
module fp_cmp_unit
  import fcmp_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  parameter int unsigned RES_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmp_en,
  input  logic [EXP_W+MAN_W:0]   opa,
  input  logic [EXP_W+MAN_W:0]   opb,
  output logic [RES_W-1:0]       cmp_res,
  output logic                   cmp_inv
);

  localparam int unsigned W     = 1 + EXP_W + MAN_W;
  localparam int unsigned N_OPS = 2;

  logic              rst_n_s;
  logic [W-1:0]      ops [N_OPS];
  fcls_t             cls [N_OPS];
  logic [REL_W-1:0]  rel;
  logic [RES_W-1:0]  res_d;
  logic              inv_d;
  logic [RES_W-1:0]  res_q;
  logic              inv_q;

  fcmp_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign ops[0] = opa;
  assign ops[1] = opb;

  for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op  (ops[gi]),
      .cls (cls[gi])
    );
  end

  fcmp_relate #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_rel (
    .opa   (opa),
    .opb   (opb),
    .cls_a (cls[0]),
    .cls_b (cls[1]),
    .rel   (rel)
  );

  // Next-state assembly of the result word.
  always_comb begin
    res_d              = '0;
    res_d[REL_W-1:0]   = rel;
    res_d[DEN_A]       = cls[0].is_sub;
    res_d[DEN_B]       = cls[1].is_sub;
    inv_d              = cls[0].is_snan || cls[1].is_snan;
  end

  // Output register stage with explicit load enable.
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      res_q <= '0;
      inv_q <= 1'b0;
    end else if (cmp_en) begin
      res_q <= res_d;
      inv_q <= inv_d;
    end
  end

  assign cmp_res = res_q;
  assign cmp_inv = inv_q;

endmodule

// File: rtl/fcmp_chk.sv
module fcmp_chk #(
  parameter int unsigned RES_W = 32,
  parameter int unsigned W     = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmp_en,
  input logic [W-1:0]     opa,
  input logic [W-1:0]     opb,
  input logic [RES_W-1:0] cmp_res,
  input logic             cmp_inv
);

  logic loaded_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
    end else if (cmp_en) begin
      loaded_q <= 1'b1;
    end
  end

  // R1
  rel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q |-> ($countones(cmp_res[3:0]) == 1));

  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_res[RES_W-1:6] == '0);

  // R6
  inv_unord_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_inv |-> cmp_res[3]);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |=> ($stable(cmp_res) && $stable(cmp_inv)));

  // R4
  zero_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && opa[W-2:0] == '0 && opb[W-2:0] == '0) |=> cmp_res[1]);

  // R10
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded_q |-> (cmp_res == '0 && !cmp_inv));

endmodule

bind fp_cmp_unit fcmp_chk #(.RES_W(RES_W), .W(1 + EXP_W + MAN_W)) u_fcmp_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cmp_en  (cmp_en),
  .opa     (opa),
  .opb     (opb),
  .cmp_res (cmp_res),
  .cmp_inv (cmp_inv)
);

// File: tb/tb_fp_cmp_unit.sv
module tb_fp_cmp_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        cmp_en;
  logic [31:0] opa;
  logic [31:0] opb;
  logic [31:0] cmp_res;
  logic        cmp_inv;

  int n_chk;
  int n_bad;
  bit done;

  fp_cmp_unit dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmp_en  (cmp_en),
    .opa     (opa),
    .opb     (opb),
    .cmp_res (cmp_res),
    .cmp_inv (cmp_inv)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit is_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic bit is_snan(input logic [31:0] x);
    return is_nan(x) && !x[22];
  endfunction

  function automatic bit is_sub(input logic [31:0] x);
    return (x[30:23] == 8'h00) && (x[22:0] != 0);
  endfunction

  // Monotonic unsigned key: larger key means larger value.
  function automatic logic [31:0] okey(input logic [31:0] x);
    if (x[30:0] == 0) return 32'h8000_0000;
    if (x[31]) return ~x;
    return x | 32'h8000_0000;
  endfunction

  function automatic logic [31:0] exp_res(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    r = '0;
    if (is_nan(a) || is_nan(b)) r[3] = 1'b1;
    else if (okey(a) < okey(b)) r[0] = 1'b1;
    else if (okey(a) == okey(b)) r[1] = 1'b1;
    else r[2] = 1'b1;
    r[4] = is_sub(a);
    r[5] = is_sub(b);
    return r;
  endfunction

  function automatic logic [31:0] pick(input int cls);
    logic [31:0] x;
    x = $urandom;
    case (cls)
      0: x[30:0] = '0;
      1: begin x[30:23] = 8'h00; if (x[22:0] == 0) x[0] = 1'b1; end
      2: begin x[30:23] = 8'hFF; x[22:0] = '0; end
      3: begin x[30:23] = 8'hFF; x[22] = 1'b1; end
      4: begin x[30:23] = 8'hFF; x[22] = 1'b0; if (x[21:0] == 0) x[3] = 1'b1; end
      5: begin if (x[30:23] == 8'h00) x[23] = 1'b1; if (x[30:23] == 8'hFF) x[30] = 1'b0; end
      default: ;
    endcase
    return x;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Apply one vector and check at the following negedge.
  task automatic apply(input string req, input logic [31:0] a, input logic [31:0] b);
    opa = a;
    opb = b;
    cmp_en = 1'b1;
    @(negedge clk);
    check(req, cmp_res, exp_res(a, b));
    check("R6 R7 invalid", {31'd0, cmp_inv}, {31'd0, is_snan(a) || is_snan(b)});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    n_chk = 0;
    n_bad = 0;
    done = 0;
    void'($urandom(32'h5EED_0C3A));
    rst_n = 1'b0;
    cmp_en = 1'b0;
    opa = 32'h3F80_0000;
    opb = 32'h0000_0001;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset res", cmp_res, 32'h0);
    check("R10 reset inv", {31'd0, cmp_inv}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 after release", cmp_res, 32'h0);

    // Directed corner cases
    apply("R1 lt", 32'h3F80_0000, 32'h4000_0000);
    apply("R1 gt", 32'hC000_0000, 32'hC040_0000);
    apply("R1 eq", 32'h4120_0000, 32'h4120_0000);
    apply("R4 +0 -0", 32'h0000_0000, 32'h8000_0000);
    apply("R4 -0 +0", 32'h8000_0000, 32'h0000_0000);
    apply("R3 R2 min sub vs +0", 32'h0000_0001, 32'h0000_0000);
    apply("R3 R2 max sub vs min normal", 32'h007F_FFFF, 32'h0080_0000);
    apply("R3 R2 neg subs", 32'h8000_0002, 32'h8000_0001);
    apply("R5 R6 qnan vs 1", 32'h7FC0_0000, 32'h3F80_0000);
    apply("R5 R6 inf vs snan", 32'h7F80_0000, 32'hFF80_0001);
    apply("R5 R2 sub vs qnan", 32'h0000_0010, 32'hFFC0_1234);
    apply("R7 inf vs -inf", 32'h7F80_0000, 32'hFF80_0000);
    apply("R8 R1 wide", 32'h7F7F_FFFF, 32'hFF7F_FFFF);

    // R9: hold while enable is low
    held = cmp_res;
    cmp_en = 1'b0;
    opa = 32'h7FA0_0000;
    opb = 32'h0000_0003;
    repeat (3) @(negedge clk);
    check("R9 hold res", cmp_res, held);
    check("R9 hold inv", {31'd0, cmp_inv}, 32'h0);

    // Constrained random: class-driven operands, shared magnitudes
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      logic [31:0] b;
      int mode;
      a = pick($urandom_range(0, 6));
      mode = $urandom_range(0, 3);
      case (mode)
        0: b = a ^ 32'h8000_0000;
        1: b = a ^ 32'h0000_0001;
        2: b = a;
        default: b = pick($urandom_range(0, 6));
      endcase
      if ($urandom_range(0, 1) == 1) apply("R1 R2 R3 R5 R8 random", a, b);
      else apply("R1 R2 R3 R5 R8 random", b, a);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule